// File: doc/BRIEF.md
# Out-of-Order Node Table with In-Order Retirement

This block is the scheduling heart of a restricted dataflow core. A decoder feeds it the operation nodes of each instruction, one node per cycle. Each node names a result tag of its own and two source operands. An operand is either already present as a value, or pending on the tag of a node that has not yet produced it. A node sits in a small table until both operands hold values. It is then dispatched to a single functional unit, and it may overtake nodes of older instructions that are still waiting. The functional unit later broadcasts each result together with its tag. Every waiting operand that names that tag copies the value.

Instructions receive identifiers from a ring of window slots. Each new instruction takes the next identifier, starting from 0. An instruction has executed once its final node has been inserted and a result has come back for every one of its nodes. Instructions leave the window strictly in program order. A store is held inside its window slot until retirement: its address arrives with the node that carries the store flag, and its data with that node's result. It becomes visible on the retire port only in the cycle the instruction retires. Insertion is refused while the table or the window has no room.

Top module: `ntab_core`

## Requirements
- R1: A node is never dispatched while either operand is pending. A dispatched node presents on the fire port its operation code, its result tag, its instruction identifier, its store flag and both operand values (fire_a from the first source, fire_b from the second).
- R2: When a broadcast's tag equals a pending operand's tag, the value is captured in the same cycle, and the node may fire from the next cycle on. This also applies to a node being inserted in the very cycle of the broadcast.
- R3: One broadcast is captured by every resident node that waits on its tag, in either operand position.
- R4: At most one node fires per cycle, and a fired node leaves the table. Among ready nodes, the one whose instruction is fewest positions past the oldest resident instruction fires first, whatever table entry it occupies.
- R5: An instruction counts as executed only when its node marked last has been inserted and results tagged with its identifier have returned for all of its nodes.
- R6: Identifiers are handed out from 0, incrementing by one per instruction modulo WIN, and ins_iid shows the identifier the next inserted node will belong to. Retirement follows identifier order, one instruction per cycle. ret_valid stays low while the oldest instruction has not executed, even if younger ones have.
- R7: A store's address comes from the inserted node with ins_st=1, and its data from the result returned with res_st=1. ret_st, ret_addr and ret_data expose them only in the retiring cycle.
- R8: ins_full is high when all NODES entries are occupied, or when WIN instructions are resident and none is still open. An insert offered while ins_full is high is ignored: it takes no entry, takes no identifier and never fires.
- R9: After reset the table and the window are empty, ins_full, fire_valid and ret_valid are low, and ins_iid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Insert a node this cycle |
| ins_last | input | 1 | Node closes its instruction |
| ins_op | input | OP_W | Operation code |
| ins_dtag | input | TAG_W | Tag the node's result will carry |
| ins_a_rdy | input | 1 | First operand value present |
| ins_a_tag | input | TAG_W | Producer tag of first operand |
| ins_a_val | input | DATA_W | First operand value |
| ins_b_rdy | input | 1 | Second operand value present |
| ins_b_tag | input | TAG_W | Producer tag of second operand |
| ins_b_val | input | DATA_W | Second operand value |
| ins_st | input | 1 | Node produces the instruction's store data |
| ins_addr | input | ADDR_W | Store address, used when ins_st is high |
| ins_full | output | 1 | Insert refused this cycle |
| ins_iid | output | IID_W | Identifier of the instruction being filled |
| fire_valid | output | 1 | A node is dispatched this cycle |
| fire_op | output | OP_W | Dispatched operation |
| fire_tag | output | TAG_W | Dispatched result tag |
| fire_iid | output | IID_W | Dispatched instruction identifier |
| fire_st | output | 1 | Dispatched node is a store producer |
| fire_a | output | DATA_W | First operand value |
| fire_b | output | DATA_W | Second operand value |
| res_valid | input | 1 | Result broadcast this cycle |
| res_tag | input | TAG_W | Result tag |
| res_iid | input | IID_W | Instruction the result belongs to |
| res_st | input | 1 | Result is store data |
| res_val | input | DATA_W | Result value |
| ret_valid | output | 1 | Oldest instruction retires this cycle |
| ret_iid | output | IID_W | Retiring identifier |
| ret_st | output | 1 | Retiring instruction commits a store |
| ret_addr | output | ADDR_W | Store address |
| ret_data | output | DATA_W | Store data |

## Verification
Two collisions matter most. The first is a broadcast and an insert landing together: the new node names the tag being broadcast, and the bench requires it to fire on the very next cycle with the broadcast value, while the producer's instruction retires in the same cycle. The second is two nodes that wake up from one broadcast. The younger instruction holds the lower entry, so the bench can see whether age, and not entry position, picks the winner. Each of the two must then fire in its own cycle with the captured value. Results returned youngest first then show that retirement still waits for the oldest instruction.

// File: rtl/ntab_pkg.sv
package ntab_pkg;
    // Default geometry shared by the core, its sub-blocks and the checker.
    parameter int NT_NODES  = 8;
    parameter int NT_WIN    = 4;   // power of two: identifiers wrap naturally
    parameter int NT_DATA_W = 16;
    parameter int NT_TAG_W  = 5;
    parameter int NT_OP_W   = 4;
    parameter int NT_ADDR_W = 12;
    parameter int NT_PEND_W = 5;
endpackage

// File: rtl/ntab_pick.sv
module ntab_pick #(
    parameter int NODES = ntab_pkg::NT_NODES,
    parameter int WIN   = ntab_pkg::NT_WIN,
    localparam int IID_W = $clog2(WIN),
    localparam int IDX_W = $clog2(NODES)
) (
    input  logic [NODES-1:0] rdy,
    input  logic [IID_W-1:0] iid [NODES],
    input  logic [IID_W-1:0] head,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    logic [IID_W-1:0] age;
    logic [IID_W-1:0] best;

    // Age is the ring distance from the oldest resident instruction;
    // strict compare keeps the lower entry on a tie.
    always_comb begin
        any  = 1'b0;
        idx  = '0;
        best = '1;
        age  = '0;
        for (int i = 0; i < NODES; i++) begin
            age = iid[i] - head;
            if (rdy[i] && (!any || age < best)) begin
                any  = 1'b1;
                idx  = IDX_W'(i);
                best = age;
            end
        end
    end
endmodule

// File: rtl/ntab_nodes.sv
module ntab_nodes #(
    parameter int NODES  = ntab_pkg::NT_NODES,
    parameter int WIN    = ntab_pkg::NT_WIN,
    parameter int DATA_W = ntab_pkg::NT_DATA_W,
    parameter int TAG_W  = ntab_pkg::NT_TAG_W,
    parameter int OP_W   = ntab_pkg::NT_OP_W,
    localparam int IID_W = $clog2(WIN),
    localparam int IDX_W = $clog2(NODES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ins_go,
    input  logic [IID_W-1:0]  ins_iid,
    input  logic [OP_W-1:0]   ins_op,
    input  logic [TAG_W-1:0]  ins_dtag,
    input  logic              ins_st,
    input  logic              ins_a_rdy,
    input  logic [TAG_W-1:0]  ins_a_tag,
    input  logic [DATA_W-1:0] ins_a_val,
    input  logic              ins_b_rdy,
    input  logic [TAG_W-1:0]  ins_b_tag,
    input  logic [DATA_W-1:0] ins_b_val,
    input  logic              res_valid,
    input  logic [TAG_W-1:0]  res_tag,
    input  logic [DATA_W-1:0] res_val,
    input  logic [IID_W-1:0]  head_iid,
    output logic              has_free,
    output logic              fire_valid,
    output logic [OP_W-1:0]   fire_op,
    output logic [TAG_W-1:0]  fire_tag,
    output logic [IID_W-1:0]  fire_iid,
    output logic              fire_st,
    output logic [DATA_W-1:0] fire_a,
    output logic [DATA_W-1:0] fire_b
);
    typedef struct packed {
        logic              vld;
        logic [IID_W-1:0]  iid;
        logic [OP_W-1:0]   op;
        logic [TAG_W-1:0]  dtag;
        logic              st;
        logic              ra;
        logic [TAG_W-1:0]  ta;
        logic [DATA_W-1:0] va;
        logic              rb;
        logic [TAG_W-1:0]  tb;
        logic [DATA_W-1:0] vb;
    } entry_t;

    typedef struct packed {
        entry_t [NODES-1:0] ent;
    } tab_t;

    tab_t q, d;

    logic [NODES-1:0] rdy;
    logic [IID_W-1:0] ent_iid [NODES];
    logic             pick_any;
    logic [IDX_W-1:0] pick_idx;
    logic [IDX_W-1:0] free_idx;
    entry_t           ne;

    for (genvar g = 0; g < NODES; g++) begin : g_ready
        assign rdy[g]     = q.ent[g].vld && q.ent[g].ra && q.ent[g].rb;
        assign ent_iid[g] = q.ent[g].iid;
    end

    ntab_pick #(.NODES(NODES), .WIN(WIN)) u_pick (
        .rdy  (rdy),
        .iid  (ent_iid),
        .head (head_iid),
        .any  (pick_any),
        .idx  (pick_idx)
    );

    always_comb begin
        d        = q;
        has_free = 1'b0;
        free_idx = '0;
        ne       = '0;

        // Lowest free entry receives the next inserted node.
        for (int i = NODES - 1; i >= 0; i--) begin
            if (!q.ent[i].vld) begin
                has_free = 1'b1;
                free_idx = IDX_W'(i);
            end
        end

        // Dispatch frees the chosen entry.
        if (pick_any) d.ent[pick_idx].vld = 1'b0;

        // Broadcast capture into every waiting operand with the same tag.
        if (res_valid) begin
            for (int i = 0; i < NODES; i++) begin
                if (q.ent[i].vld && !q.ent[i].ra && q.ent[i].ta == res_tag) begin
                    d.ent[i].ra = 1'b1;
                    d.ent[i].va = res_val;
                end
                if (q.ent[i].vld && !q.ent[i].rb && q.ent[i].tb == res_tag) begin
                    d.ent[i].rb = 1'b1;
                    d.ent[i].vb = res_val;
                end
            end
        end

        // Insert, with bypass of a broadcast arriving in the same cycle.
        if (ins_go) begin
            ne.vld  = 1'b1;
            ne.iid  = ins_iid;
            ne.op   = ins_op;
            ne.dtag = ins_dtag;
            ne.st   = ins_st;
            ne.ra   = ins_a_rdy;
            ne.ta   = ins_a_tag;
            ne.va   = ins_a_val;
            ne.rb   = ins_b_rdy;
            ne.tb   = ins_b_tag;
            ne.vb   = ins_b_val;
            if (!ins_a_rdy && res_valid && ins_a_tag == res_tag) begin
                ne.ra = 1'b1;
                ne.va = res_val;
            end
            if (!ins_b_rdy && res_valid && ins_b_tag == res_tag) begin
                ne.rb = 1'b1;
                ne.vb = res_val;
            end
            d.ent[free_idx] = ne;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign fire_valid = pick_any;
    assign fire_op    = q.ent[pick_idx].op;
    assign fire_tag   = q.ent[pick_idx].dtag;
    assign fire_iid   = q.ent[pick_idx].iid;
    assign fire_st    = q.ent[pick_idx].st;
    assign fire_a     = q.ent[pick_idx].va;
    assign fire_b     = q.ent[pick_idx].vb;
endmodule

// File: rtl/ntab_window.sv
module ntab_window #(
    parameter int WIN    = ntab_pkg::NT_WIN,
    parameter int PEND_W = ntab_pkg::NT_PEND_W,
    parameter int DATA_W = ntab_pkg::NT_DATA_W,
    parameter int ADDR_W = ntab_pkg::NT_ADDR_W,
    localparam int IID_W = $clog2(WIN),
    localparam int CNT_W = $clog2(WIN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ins_go,
    input  logic              ins_last,
    input  logic              ins_st,
    input  logic [ADDR_W-1:0] ins_addr,
    input  logic              res_valid,
    input  logic [IID_W-1:0]  res_iid,
    input  logic              res_st,
    input  logic [DATA_W-1:0] res_val,
    output logic [IID_W-1:0]  cur_iid,
    output logic [IID_W-1:0]  head_iid,
    output logic              win_full,
    output logic              open,
    output logic              ret_valid,
    output logic [IID_W-1:0]  ret_iid,
    output logic              ret_st,
    output logic [ADDR_W-1:0] ret_addr,
    output logic [DATA_W-1:0] ret_data
);
    typedef struct packed {
        logic              busy;
        logic              closed;
        logic [PEND_W-1:0] pend;
        logic              has_st;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } slot_t;

    typedef struct packed {
        slot_t [WIN-1:0]  slot;
        logic [IID_W-1:0] head;
        logic [IID_W-1:0] tail;
        logic [CNT_W-1:0] cnt;
        logic             open;
    } win_t;

    win_t  q, d;
    slot_t hs;
    logic  ret_go;
    logic  new_ins;

    always_comb begin
        d       = q;
        hs      = q.slot[q.head];
        ret_go  = hs.busy && hs.closed && (hs.pend == '0);
        cur_iid = q.open ? q.tail - 1'b1 : q.tail;
        new_ins = ins_go && !q.open;

        if (ret_go) begin
            d.slot[q.head].busy = 1'b0;
            d.head = q.head + 1'b1;
        end

        if (res_valid) begin
            d.slot[res_iid].pend = d.slot[res_iid].pend - 1'b1;
            if (res_st) d.slot[res_iid].data = res_val;
        end

        if (ins_go) begin
            if (new_ins) begin
                d.slot[q.tail]      = '0;
                d.slot[q.tail].busy = 1'b1;
                d.tail              = q.tail + 1'b1;
            end
            d.slot[cur_iid].pend = d.slot[cur_iid].pend + 1'b1;
            if (ins_st) begin
                d.slot[cur_iid].has_st = 1'b1;
                d.slot[cur_iid].addr   = ins_addr;
            end
            if (ins_last) d.slot[cur_iid].closed = 1'b1;
            d.open = !ins_last;
        end

        d.cnt = q.cnt + CNT_W'(new_ins) - CNT_W'(ret_go);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign head_iid  = q.head;
    assign win_full  = (q.cnt == CNT_W'(WIN));
    assign open      = q.open;
    assign ret_valid = ret_go;
    assign ret_iid   = q.head;
    assign ret_st    = ret_go && hs.has_st;
    assign ret_addr  = hs.addr;
    assign ret_data  = hs.data;
endmodule

// File: rtl/ntab_core.sv
module ntab_core #(
    parameter int NODES  = ntab_pkg::NT_NODES,
    parameter int WIN    = ntab_pkg::NT_WIN,
    parameter int DATA_W = ntab_pkg::NT_DATA_W,
    parameter int TAG_W  = ntab_pkg::NT_TAG_W,
    parameter int OP_W   = ntab_pkg::NT_OP_W,
    parameter int ADDR_W = ntab_pkg::NT_ADDR_W,
    parameter int PEND_W = ntab_pkg::NT_PEND_W,
    localparam int IID_W = $clog2(WIN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ins_valid,
    input  logic              ins_last,
    input  logic [OP_W-1:0]   ins_op,
    input  logic [TAG_W-1:0]  ins_dtag,
    input  logic              ins_a_rdy,
    input  logic [TAG_W-1:0]  ins_a_tag,
    input  logic [DATA_W-1:0] ins_a_val,
    input  logic              ins_b_rdy,
    input  logic [TAG_W-1:0]  ins_b_tag,
    input  logic [DATA_W-1:0] ins_b_val,
    input  logic              ins_st,
    input  logic [ADDR_W-1:0] ins_addr,
    output logic              ins_full,
    output logic [IID_W-1:0]  ins_iid,
    output logic              fire_valid,
    output logic [OP_W-1:0]   fire_op,
    output logic [TAG_W-1:0]  fire_tag,
    output logic [IID_W-1:0]  fire_iid,
    output logic              fire_st,
    output logic [DATA_W-1:0] fire_a,
    output logic [DATA_W-1:0] fire_b,
    input  logic              res_valid,
    input  logic [TAG_W-1:0]  res_tag,
    input  logic [IID_W-1:0]  res_iid,
    input  logic              res_st,
    input  logic [DATA_W-1:0] res_val,
    output logic              ret_valid,
    output logic [IID_W-1:0]  ret_iid,
    output logic              ret_st,
    output logic [ADDR_W-1:0] ret_addr,
    output logic [DATA_W-1:0] ret_data
);
    logic             has_free;
    logic             win_full;
    logic             win_open;
    logic             ins_go;
    logic [IID_W-1:0] head_iid;

    // A node needs a free entry; a new instruction also needs a free slot.
    assign ins_full = !has_free || (!win_open && win_full);
    assign ins_go   = ins_valid && !ins_full;

    ntab_window #(
        .WIN(WIN), .PEND_W(PEND_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
    ) u_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .ins_go    (ins_go),
        .ins_last  (ins_last),
        .ins_st    (ins_st),
        .ins_addr  (ins_addr),
        .res_valid (res_valid),
        .res_iid   (res_iid),
        .res_st    (res_st),
        .res_val   (res_val),
        .cur_iid   (ins_iid),
        .head_iid  (head_iid),
        .win_full  (win_full),
        .open      (win_open),
        .ret_valid (ret_valid),
        .ret_iid   (ret_iid),
        .ret_st    (ret_st),
        .ret_addr  (ret_addr),
        .ret_data  (ret_data)
    );

    ntab_nodes #(
        .NODES(NODES), .WIN(WIN), .DATA_W(DATA_W), .TAG_W(TAG_W), .OP_W(OP_W)
    ) u_nodes (
        .clk        (clk),
        .rst_n      (rst_n),
        .ins_go     (ins_go),
        .ins_iid    (ins_iid),
        .ins_op     (ins_op),
        .ins_dtag   (ins_dtag),
        .ins_st     (ins_st),
        .ins_a_rdy  (ins_a_rdy),
        .ins_a_tag  (ins_a_tag),
        .ins_a_val  (ins_a_val),
        .ins_b_rdy  (ins_b_rdy),
        .ins_b_tag  (ins_b_tag),
        .ins_b_val  (ins_b_val),
        .res_valid  (res_valid),
        .res_tag    (res_tag),
        .res_val    (res_val),
        .head_iid   (head_iid),
        .has_free   (has_free),
        .fire_valid (fire_valid),
        .fire_op    (fire_op),
        .fire_tag   (fire_tag),
        .fire_iid   (fire_iid),
        .fire_st    (fire_st),
        .fire_a     (fire_a),
        .fire_b     (fire_b)
    );
endmodule

// File: rtl/ntab_core_chk.sv
module ntab_core_chk #(
    parameter int NODES = ntab_pkg::NT_NODES,
    parameter int WIN   = ntab_pkg::NT_WIN,
    localparam int IID_W = $clog2(WIN),
    localparam int OCC_W = $clog2(NODES + 1),
    localparam int CNT_W = $clog2(WIN + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ins_valid,
    input logic             ins_last,
    input logic             ins_full,
    input logic             fire_valid,
    input logic             ret_valid,
    input logic [IID_W-1:0] ret_iid,
    input logic             ret_st
);
    logic [OCC_W-1:0] occ;
    logic [CNT_W-1:0] wcnt;
    logic             open_c;
    logic [IID_W-1:0] exp_ret;
    logic             acc;

    assign acc = ins_valid && !ins_full;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ     <= '0;
            wcnt    <= '0;
            open_c  <= 1'b0;
            exp_ret <= '0;
        end else begin
            occ  <= occ + OCC_W'(acc) - OCC_W'(fire_valid);
            wcnt <= wcnt + CNT_W'(acc && !open_c) - CNT_W'(ret_valid);
            if (acc) open_c <= !ins_last;
            if (ret_valid) exp_ret <= exp_ret + 1'b1;
        end
    end

    p_fire_has_node_r1: assert property (@(posedge clk) disable iff (!rst_n)
        fire_valid |-> occ != '0);

    p_retire_has_instr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid |-> wcnt != '0);

    p_retire_in_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid |-> ret_iid == exp_ret);

    p_store_at_retire_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ret_st |-> ret_valid);

    p_node_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == OCC_W'(NODES)) |-> ins_full);

    p_occ_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= OCC_W'(NODES));

    p_window_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wcnt == CNT_W'(WIN) && !open_c) |-> ins_full);
endmodule

bind ntab_core ntab_core_chk #(.NODES(NODES), .WIN(WIN)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ins_valid  (ins_valid),
    .ins_last   (ins_last),
    .ins_full   (ins_full),
    .fire_valid (fire_valid),
    .ret_valid  (ret_valid),
    .ret_iid    (ret_iid),
    .ret_st     (ret_st)
);

// File: tb/ntab_core_bench.sv
`timescale 1ns/1ps
module ntab_core_bench;
    localparam int NODES  = 8;
    localparam int WIN    = 4;
    localparam int DATA_W = 16;
    localparam int TAG_W  = 5;
    localparam int OP_W   = 4;
    localparam int ADDR_W = 12;
    localparam int IID_W  = $clog2(WIN);

    // {store, addr[11:0], a[15:0], b[15:0]}
    localparam logic [44:0] VEC [6] = '{
        {1'b0, 12'h000, 16'h0011, 16'h0022},
        {1'b1, 12'h3A5, 16'h1000, 16'h0234},
        {1'b0, 12'h000, 16'hFFFF, 16'h0001},
        {1'b1, 12'hFFF, 16'h7FFF, 16'h7FFF},
        {1'b1, 12'h001, 16'h0000, 16'h0000},
        {1'b0, 12'h000, 16'hA5A5, 16'h5A5A}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic              ins_valid = 0, ins_last = 0, ins_a_rdy = 0, ins_b_rdy = 0, ins_st = 0;
    logic [OP_W-1:0]   ins_op = '0;
    logic [TAG_W-1:0]  ins_dtag = '0, ins_a_tag = '0, ins_b_tag = '0;
    logic [DATA_W-1:0] ins_a_val = '0, ins_b_val = '0;
    logic [ADDR_W-1:0] ins_addr = '0;
    logic              ins_full;
    logic [IID_W-1:0]  ins_iid;
    logic              fire_valid, fire_st;
    logic [OP_W-1:0]   fire_op;
    logic [TAG_W-1:0]  fire_tag;
    logic [IID_W-1:0]  fire_iid;
    logic [DATA_W-1:0] fire_a, fire_b;
    logic              res_valid = 0, res_st = 0;
    logic [TAG_W-1:0]  res_tag = '0;
    logic [IID_W-1:0]  res_iid = '0;
    logic [DATA_W-1:0] res_val = '0;
    logic              ret_valid, ret_st;
    logic [IID_W-1:0]  ret_iid;
    logic [ADDR_W-1:0] ret_addr;
    logic [DATA_W-1:0] ret_data;

    ntab_core u_ntab_core (.*);

    int checks = 0;
    int errors = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        ins_valid = 0; ins_last = 0; ins_st = 0;
        res_valid = 0; res_st = 0;
    endtask

    task automatic put_ins(input logic [OP_W-1:0] op, input logic [TAG_W-1:0] dtag,
                           input logic ar, input logic [TAG_W-1:0] at, input logic [DATA_W-1:0] av,
                           input logic br, input logic [TAG_W-1:0] bt, input logic [DATA_W-1:0] bv,
                           input logic st, input logic [ADDR_W-1:0] addr, input logic last);
        ins_valid = 1; ins_op = op; ins_dtag = dtag;
        ins_a_rdy = ar; ins_a_tag = at; ins_a_val = av;
        ins_b_rdy = br; ins_b_tag = bt; ins_b_val = bv;
        ins_st = st; ins_addr = addr; ins_last = last;
    endtask

    task automatic put_res(input logic [TAG_W-1:0] tag, input logic [IID_W-1:0] iid,
                           input logic st, input logic [DATA_W-1:0] val);
        res_valid = 1; res_tag = tag; res_iid = iid; res_st = st; res_val = val;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog act=%0h exp=%0h", 1, 0);
        summary();
    end

    initial begin
        logic [IID_W-1:0] eid;
        logic [IID_W-1:0] ia, ib, ic;
        eid = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R9 reset state
        chk(!fire_valid, "R9 fire_valid", fire_valid, 0);
        chk(!ret_valid, "R9 ret_valid", ret_valid, 0);
        chk(!ins_full, "R9 ins_full", ins_full, 0);
        chk(ins_iid == 0, "R9 ins_iid", ins_iid, 0);

        // Table walk: single-node instructions, R1 R6 R7
        for (int k = 0; k < 6; k++) begin
            logic st;
            logic [ADDR_W-1:0] ad;
            logic [DATA_W-1:0] a, b, sum;
            st = VEC[k][44]; ad = VEC[k][43:32]; a = VEC[k][31:16]; b = VEC[k][15:0];
            sum = a + b;
            chk(ins_iid == eid, "R6 ins_iid", ins_iid, eid);
            put_ins(OP_W'(k), TAG_W'(k), 1, '0, a, 1, '0, b, st, ad, 1);
            tick();
            chk(fire_valid && fire_op == OP_W'(k) && fire_tag == TAG_W'(k), "R1 fire op/tag",
                {fire_valid, fire_op, fire_tag}, {1'b1, OP_W'(k), TAG_W'(k)});
            chk(fire_a == a && fire_b == b, "R1 fire operands", {fire_a, fire_b}, {a, b});
            chk(fire_iid == eid && fire_st == st, "R1 fire iid/st", {fire_iid, fire_st}, {eid, st});
            tick();
            chk(!fire_valid && !ret_valid, "R4 fired node left", {fire_valid, ret_valid}, 0);
            put_res(TAG_W'(k), eid, st, sum);
            tick();
            chk(ret_valid && ret_iid == eid, "R6 retire id", {ret_valid, ret_iid}, {1'b1, eid});
            chk(ret_st == st, "R7 ret_st", ret_st, st);
            if (st) chk(ret_addr == ad && ret_data == sum, "R7 store addr/data",
                        {ret_addr, ret_data}, {ad, sum});
            tick();
            chk(!ret_valid, "R6 one retire", ret_valid, 0);
            eid = eid + 1'b1;
        end

        // R2 bypass: consumer inserted in the producer's broadcast cycle
        ia = eid; ib = eid + 1'b1;
        put_ins(4'h1, 5'd10, 1, '0, 16'h0003, 1, '0, 16'h0004, 0, '0, 1);
        tick(); tick();
        put_res(5'd10, ia, 0, 16'h1234);
        put_ins(4'h2, 5'd11, 1, '0, 16'h0005, 0, 5'd10, 16'h0000, 0, '0, 1);
        tick();
        chk(fire_valid && fire_tag == 5'd11 && fire_b == 16'h1234, "R2 insert bypass",
            {fire_valid, fire_tag, fire_b}, {1'b1, 5'd11, 16'h1234});
        chk(ret_valid && ret_iid == ia, "R6 producer retires", {ret_valid, ret_iid}, {1'b1, ia});
        tick();
        put_res(5'd11, ib, 0, 16'h0000);
        tick();
        chk(ret_valid && ret_iid == ib, "R5 consumer executed", {ret_valid, ret_iid}, {1'b1, ib});
        tick();
        eid = eid + 2'd2;

        // R3 R4: two waiters, older one in the higher entry
        ia = eid; ib = eid + 1'b1; ic = eid + 2'd2;
        put_ins(4'h0, 5'd1, 1, '0, 16'h0001, 1, '0, 16'h0001, 0, '0, 1);
        tick();
        put_ins(4'h0, 5'd2, 0, 5'd1, '0, 1, '0, 16'h0010, 0, '0, 1);
        tick();
        put_ins(4'h0, 5'd3, 1, '0, 16'h0020, 0, 5'd1, '0, 0, '0, 1);
        tick();
        chk(!fire_valid, "R1 waiting nodes hold", fire_valid, 0);
        tick();
        chk(!fire_valid, "R1 still waiting", fire_valid, 0);
        put_res(5'd1, ia, 0, 16'h0042);
        tick();
        chk(fire_valid && fire_iid == ib && fire_tag == 5'd2, "R4 oldest first",
            {fire_valid, fire_iid, fire_tag}, {1'b1, ib, 5'd2});
        chk(fire_a == 16'h0042, "R3 capture first operand", fire_a, 16'h0042);
        chk(ret_valid && ret_iid == ia, "R6 producer retires", {ret_valid, ret_iid}, {1'b1, ia});
        tick();
        chk(fire_valid && fire_tag == 5'd3 && fire_b == 16'h0042, "R3 capture second operand",
            {fire_valid, fire_tag, fire_b}, {1'b1, 5'd3, 16'h0042});
        chk(!ret_valid, "R6 no extra retire", ret_valid, 0);
        tick();
        chk(!fire_valid, "R4 one per cycle", fire_valid, 0);
        // R6: younger completes first, must wait
        put_res(5'd3, ic, 0, 16'h0000);
        tick();
        chk(!ret_valid, "R6 younger waits", ret_valid, 0);
        tick();
        chk(!ret_valid, "R6 younger still waits", ret_valid, 0);
        put_res(5'd2, ib, 0, 16'h0000);
        tick();
        chk(ret_valid && ret_iid == ib, "R6 older first", {ret_valid, ret_iid}, {1'b1, ib});
        tick();
        chk(ret_valid && ret_iid == ic, "R6 then younger", {ret_valid, ret_iid}, {1'b1, ic});
        tick();
        chk(!ret_valid, "R6 drained", ret_valid, 0);
        eid = eid + 2'd3;

        // R5 R7: two-node instruction with a store
        chk(ins_iid == eid, "R6 ins_iid", ins_iid, eid);
        put_ins(4'h3, 5'd4, 1, '0, 16'h0001, 1, '0, 16'h0002, 0, '0, 0);
        tick();
        put_ins(4'h4, 5'd5, 1, '0, 16'h0003, 1, '0, 16'h0004, 1, 12'hABC, 1);
        tick();
        chk(fire_valid && fire_tag == 5'd5 && fire_st, "R1 store node fires",
            {fire_valid, fire_tag, fire_st}, {1'b1, 5'd5, 1'b1});
        tick();
        put_res(5'd5, eid, 1, 16'h5555);
        tick();
        chk(!ret_valid, "R5 one node outstanding", ret_valid, 0);
        chk(!ret_st, "R7 store held", ret_st, 0);
        put_res(5'd4, eid, 0, 16'h0001);
        tick();
        chk(ret_valid && ret_st && ret_addr == 12'hABC && ret_data == 16'h5555, "R7 store at retire",
            {ret_valid, ret_st, ret_addr, ret_data}, {1'b1, 1'b1, 12'hABC, 16'h5555});
        tick();
        eid = eid + 1'b1;

        // R8: table full of nodes
        ia = eid; ib = eid + 1'b1;
        put_ins(4'h0, 5'd20, 1, '0, 16'h0001, 1, '0, 16'h0001, 0, '0, 1);
        tick(); tick();
        for (int i = 0; i < NODES; i++) begin
            chk(!ins_full, "R8 room left", ins_full, 0);
            put_ins(4'h0, TAG_W'(21 + i), 0, 5'd20, '0, 1, '0, 16'h0000, 0, '0, (i == NODES - 1));
            tick();
        end
        chk(ins_full, "R8 table full", ins_full, 1);
        put_ins(4'h0, 5'd31, 1, '0, 16'h0001, 1, '0, 16'h0001, 0, '0, 1);
        tick();
        chk(!fire_valid, "R8 refused insert", fire_valid, 0);
        put_res(5'd20, ia, 0, 16'h0007);
        tick();
        chk(ret_valid && ret_iid == ia, "R6 producer retires", {ret_valid, ret_iid}, {1'b1, ia});
        for (int i = 0; i < NODES; i++) begin
            chk(fire_valid && fire_tag == TAG_W'(21 + i) && fire_a == 16'h0007, "R3 broadcast to all",
                {fire_valid, fire_tag, fire_a}, {1'b1, TAG_W'(21 + i), 16'h0007});
            tick();
        end
        chk(!fire_valid && !ins_full, "R8 table drained", {fire_valid, ins_full}, 0);
        chk(ins_iid == ib + 1'b1, "R8 refused insert took no id", ins_iid, ib + 1'b1);
        for (int i = 0; i < NODES; i++) begin
            put_res(TAG_W'(21 + i), ib, 0, '0);
            tick();
        end
        chk(ret_valid && ret_iid == ib, "R5 all nodes back", {ret_valid, ret_iid}, {1'b1, ib});
        tick();
        eid = eid + 2'd2;

        // R8: window full of instructions; results returned youngest first
        for (int i = 0; i < WIN; i++) begin
            put_ins(4'h0, TAG_W'(i), 1, '0, 16'h0001, 1, '0, 16'h0001, 0, '0, 1);
            tick();
        end
        tick();
        chk(ins_full, "R8 window full", ins_full, 1);
        put_ins(4'h0, 5'd15, 1, '0, 16'h0001, 1, '0, 16'h0001, 0, '0, 1);
        tick(); tick();
        chk(!fire_valid && ins_full, "R8 window refuse", {fire_valid, ins_full}, {1'b0, 1'b1});
        for (int i = WIN - 1; i >= 1; i--) begin
            put_res(TAG_W'(i), eid + IID_W'(i), 0, '0);
            tick();
            chk(!ret_valid, "R6 oldest pending", ret_valid, 0);
        end
        put_res(5'd0, eid, 0, '0);
        tick();
        for (int i = 0; i < WIN; i++) begin
            chk(ret_valid && ret_iid == eid + IID_W'(i), "R6 in-order burst",
                {ret_valid, ret_iid}, {1'b1, eid + IID_W'(i)});
            tick();
        end
        chk(!ret_valid && !ins_full && ins_iid == eid, "R8 window freed",
            {ret_valid, ins_full, ins_iid}, {1'b0, 1'b0, eid});

        summary();
    end
endmodule